// File: doc/BRIEF.md
# Fast Asynchronous Serial Port with Flow Control

This block is a byte-wide asynchronous serial port for a 48 MHz clock domain. It sends and receives 8-N-1 frames: one low start bit, eight data bits with the least significant bit first, and one high stop bit. The line idles high. The bit period is the divisor plus one clock cycles. Software works through a small register bus with five word registers. Writing the data register queues one byte for transmission. Reading it returns the oldest received byte, and a read strobe pops that byte. Received bytes collect in an eight-entry FIFO.

Transmission can be gated by a clear-to-send input. When gating is enabled, the port raises its request-to-send output as soon as a byte is pending. The start bit waits until clear-to-send is seen high. Two ten-bit block counters hold the remaining length of a block transfer. Software loads each one with the length minus one. Each counter steps down by one per byte and stops at zero.

The transmitter walks the states TX_IDLE, TX_WAIT_CTS, TX_START, TX_DATA and TX_STOP:
- TX_IDLE to TX_WAIT_CTS when a byte is pending.
- TX_WAIT_CTS to TX_START once gating is off or clear-to-send is high.
- TX_START to TX_DATA after one bit period.
- TX_DATA to TX_STOP after the eighth bit.
- TX_STOP to TX_IDLE after the stop bit.

The receiver walks the states RX_IDLE, RX_HALF, RX_DATA and RX_STOP:
- RX_IDLE to RX_HALF on a low line.
- RX_HALF to RX_DATA if the line is still low half a bit later.
- RX_HALF back to RX_IDLE if the line has gone high, which treats the low as a glitch.
- RX_DATA to RX_STOP after eight mid-bit samples.
- RX_STOP to RX_IDLE after sampling the stop bit.

Top module: `hsu_top`

## Requirements
- R1: After reset, the registers read as follows. The divisor (address 2) reads 0x0017. The status register (address 1) reads 0x0002, which means transmit-ready set and every other flag clear. Both block counters (addresses 3 and 4) read 0. The txd output is high and rts is low.
- R2: A write to address 2 is taken only if the whole 16-bit value lies between 23 and 4999 inclusive. Any other value leaves the divisor unchanged. One bit lasts divisor+1 clock cycles.
- R3: Each frame on txd is sent in this order: one low start bit, data bits 0 to 7, then one high stop bit. The line is high between frames.
- R4: A write to address 0 while transmit-ready (status bit 1) is high queues the byte and drives transmit-ready low. The start bit follows within one bit period when gating is off. A write to address 0 while transmit-ready is low is ignored.
- R5: Transmit-ready goes high again at the start of the last data bit of the frame in flight, within 4 cycles. A byte written from then on is sent right after the current frame.
- R6: When status bit 0 (gate enable, written through address 1 bit 0) is set, rts is high while a byte is pending or being sent. The start bit is held while cts is low and follows within 5 cycles of cts going high. When bit 0 is clear, cts has no effect.
- R7: The receiver confirms the start bit at mid-bit and samples each data bit at mid-bit. A frame with a high stop bit is placed in the FIFO. Address 0 returns the oldest byte in bits 7:0. A read strobe at address 0 pops that byte. Status bit 2 shows that the FIFO is not empty.
- R8: Status bit 3 is set exactly while the FIFO holds eight bytes.
- R9: A good frame that arrives while the FIFO is full is dropped and sets the sticky status bit 5. Writing 1 to address 1 bit 5 clears it.
- R10: A frame whose stop bit is sampled low is discarded and sets the sticky status bit 4. Writing 1 to address 1 bit 4 clears it.
- R11: Address 3 (transmit) and address 4 (receive) are block counters. Each loads from a write, drops by one per transmitted byte or per good received frame, stays at 0, and reads back the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; pops the FIFO at address 0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on bus_addr |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rts | output | 1 | Request to send |
| cts | input | 1 | Clear to send, high allows transmission |

## Verification
Register writes show on the read port in the cycle after the write edge. With gating off, the start bit begins two cycles after a data write. It begins three cycles after cts rises, because of the two-stage synchronizer. The bench counts edges from the observed falling edge of the start bit and samples txd at the middle of each bit period. It checks transmit-ready just before and just after the start of the last data bit. A received byte appears about nine and a half bit periods after its start bit. The bench polls for it with a bounded wait and reads the counters only after the stop bit has finished, so each result is sampled only once it is due.

// File: rtl/hsu_pkg.sv
package hsu_pkg;
    typedef enum logic [2:0] {
        TX_IDLE, TX_WAIT_CTS, TX_START, TX_DATA, TX_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE, RX_HALF, RX_DATA, RX_STOP
    } rx_state_t;

    localparam logic [2:0] ADDR_DATA  = 3'd0;
    localparam logic [2:0] ADDR_CTRL  = 3'd1;
    localparam logic [2:0] ADDR_DIV   = 3'd2;
    localparam logic [2:0] ADDR_TXCNT = 3'd3;
    localparam logic [2:0] ADDR_RXCNT = 3'd4;

    localparam int BIT_GATE = 0;
    localparam int BIT_FERR = 4;
    localparam int BIT_OVF  = 5;
endpackage

// File: rtl/hsu_fifo.sv
module hsu_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    input  logic                         pop,
    output logic [WIDTH-1:0]             dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH-1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_pop_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/hsu_tx.sv
module hsu_tx
    import hsu_pkg::*;
#(
    parameter int DIV_W  = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              flow_en,
    input  logic              cts_ok,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              ready,
    output logic              byte_done,
    output logic              txd,
    output logic              rts
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W-1);

    tx_state_t         state, nxt;
    logic [DIV_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg, hold;
    logic              hold_v, tick;

    assign tick  = (cnt == '0);
    assign ready = !hold_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            idx    <= '0;
            shreg  <= '0;
            hold   <= '0;
            hold_v <= 1'b0;
        end else begin
            if (load && !hold_v) begin
                hold   <= load_data;
                hold_v <= 1'b1;
            end
            unique case (state)
                TX_IDLE: ;
                TX_WAIT_CTS: if (nxt == TX_START) begin
                    cnt   <= div;
                    shreg <= hold;
                end
                TX_START: if (tick) begin
                    cnt <= div;
                    idx <= '0;
                end else cnt <= cnt - 1'b1;
                TX_DATA: if (tick) begin
                    cnt   <= div;
                    shreg <= shreg >> 1;
                    idx   <= idx + 1'b1;
                    if (idx == LAST - 1'b1) hold_v <= 1'b0;
                end else cnt <= cnt - 1'b1;
                TX_STOP: if (!tick) cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:     if (hold_v) nxt = TX_WAIT_CTS;
            TX_WAIT_CTS: if (!flow_en || cts_ok) nxt = TX_START;
            TX_START:    if (tick) nxt = TX_DATA;
            TX_DATA:     if (tick && idx == LAST) nxt = TX_STOP;
            TX_STOP:     if (tick) nxt = TX_IDLE;
            default:     nxt = TX_IDLE;
        endcase
    end

    always_comb begin
        txd       = 1'b1;
        rts       = 1'b0;
        byte_done = 1'b0;
        unique case (state)
            TX_IDLE: ;
            TX_WAIT_CTS: rts = flow_en;
            TX_START: begin txd = 1'b0; rts = flow_en; end
            TX_DATA:  begin txd = shreg[0]; rts = flow_en; end
            TX_STOP:  begin rts = flow_en; byte_done = tick; end
            default: ;
        endcase
    end

    assert_ready_falls_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(load));
    assert_ready_at_last_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (state == TX_DATA && idx == LAST));
    assert_start_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_START && $past(state) == TX_WAIT_CTS) |-> $past(!flow_en || cts_ok));
endmodule

// File: rtl/hsu_rx.sv
module hsu_rx
    import hsu_pkg::*;
#(
    parameter int DIV_W  = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              rxd_s,
    output logic              got_byte,
    output logic              bad_stop,
    output logic [DATA_W-1:0] got_data
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W-1);

    rx_state_t         state, nxt;
    logic [DIV_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              tick;

    assign tick     = (cnt == '0);
    assign got_data = shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
        end else begin
            unique case (state)
                RX_IDLE: if (!rxd_s) cnt <= div >> 1;
                RX_HALF: if (tick) begin
                    cnt <= div;
                    idx <= '0;
                end else cnt <= cnt - 1'b1;
                RX_DATA: if (tick) begin
                    cnt   <= div;
                    shreg <= {rxd_s, shreg[DATA_W-1:1]};
                    idx   <= idx + 1'b1;
                end else cnt <= cnt - 1'b1;
                RX_STOP: if (!tick) cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE: if (!rxd_s) nxt = RX_HALF;
            RX_HALF: if (tick) nxt = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA: if (tick && idx == LAST) nxt = RX_STOP;
            RX_STOP: if (tick) nxt = RX_IDLE;
            default: nxt = RX_IDLE;
        endcase
    end

    always_comb begin
        got_byte = 1'b0;
        bad_stop = 1'b0;
        unique case (state)
            RX_STOP: begin
                got_byte = tick && rxd_s;
                bad_stop = tick && !rxd_s;
            end
            default: ;
        endcase
    end

    assert_start_confirmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA && $past(state) == RX_HALF) |-> $past(!rxd_s));
    assert_eight_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_STOP && $past(state) == RX_DATA) |-> $past(idx) == LAST);
endmodule

// File: rtl/hsu_top.sv
module hsu_top
    import hsu_pkg::*;
#(
    parameter int BUS_W      = 16,
    parameter int DIV_W      = 13,
    parameter int DIV_RESET  = 23,
    parameter int DIV_MIN    = 23,
    parameter int DIV_MAX    = 4999,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             txd,
    input  logic             rxd,
    output logic             rts,
    input  logic             cts
);
    localparam int FCNT_W = $clog2(FIFO_DEPTH+1);

    logic [DIV_W-1:0]  div_q;
    logic              flow_en, frame_err, overflow;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic              rxd_m, rxd_s, cts_m, cts_s;
    logic              tx_ready, tx_done, rx_got, rx_bad;
    logic [DATA_W-1:0] rx_data, fifo_dout;
    logic [FCNT_W-1:0] fifo_count;
    logic              fifo_full, fifo_empty;
    logic              wr_data, wr_ctrl, wr_div, wr_txc, wr_rxc, rd_pop, div_ok;

    assign wr_data = bus_wr && bus_addr == ADDR_DATA;
    assign wr_ctrl = bus_wr && bus_addr == ADDR_CTRL;
    assign wr_div  = bus_wr && bus_addr == ADDR_DIV;
    assign wr_txc  = bus_wr && bus_addr == ADDR_TXCNT;
    assign wr_rxc  = bus_wr && bus_addr == ADDR_RXCNT;
    assign rd_pop  = bus_rd && bus_addr == ADDR_DATA;
    assign div_ok  = bus_wdata >= BUS_W'(DIV_MIN) && bus_wdata <= BUS_W'(DIV_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_m <= 1'b1; rxd_s <= 1'b1;
            cts_m <= 1'b0; cts_s <= 1'b0;
        end else begin
            rxd_m <= rxd;  rxd_s <= rxd_m;
            cts_m <= cts;  cts_s <= cts_m;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q     <= DIV_W'(DIV_RESET);
            flow_en   <= 1'b0;
            frame_err <= 1'b0;
            overflow  <= 1'b0;
            tx_cnt    <= '0;
            rx_cnt    <= '0;
        end else begin
            if (wr_div && div_ok) div_q <= bus_wdata[DIV_W-1:0];
            if (wr_ctrl) begin
                flow_en <= bus_wdata[BIT_GATE];
                if (bus_wdata[BIT_FERR]) frame_err <= 1'b0;
                if (bus_wdata[BIT_OVF])  overflow  <= 1'b0;
            end
            if (rx_bad)              frame_err <= 1'b1;
            if (rx_got && fifo_full) overflow  <= 1'b1;
            if (wr_txc)                      tx_cnt <= bus_wdata[CNT_W-1:0];
            else if (tx_done && tx_cnt != 0) tx_cnt <= tx_cnt - 1'b1;
            if (wr_rxc)                      rx_cnt <= bus_wdata[CNT_W-1:0];
            else if (rx_got && rx_cnt != 0)  rx_cnt <= rx_cnt - 1'b1;
        end
    end

    hsu_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .div(div_q), .flow_en(flow_en), .cts_ok(cts_s),
        .load(wr_data), .load_data(bus_wdata[DATA_W-1:0]), .ready(tx_ready),
        .byte_done(tx_done), .txd(txd), .rts(rts)
    );

    hsu_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .div(div_q), .rxd_s(rxd_s),
        .got_byte(rx_got), .bad_stop(rx_bad), .got_data(rx_data)
    );

    hsu_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(rx_got), .din(rx_data), .pop(rd_pop),
        .dout(fifo_dout), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_DATA:  bus_rdata = BUS_W'(fifo_dout);
            ADDR_CTRL:  bus_rdata = BUS_W'({overflow, frame_err, fifo_full,
                                            !fifo_empty, tx_ready, flow_en});
            ADDR_DIV:   bus_rdata = BUS_W'(div_q);
            ADDR_TXCNT: bus_rdata = BUS_W'(tx_cnt);
            ADDR_RXCNT: bus_rdata = BUS_W'(rx_cnt);
            default:    bus_rdata = '0;
        endcase
    end

    assert_div_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_q >= DIV_W'(DIV_MIN) && div_q <= DIV_W'(DIV_MAX));
    assert_overflow_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(fifo_full && rx_got));
    assert_ferr_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> $past(rx_bad));
    assert_txcnt_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt != $past(tx_cnt) && !$past(wr_txc)) |-> tx_cnt == $past(tx_cnt) - 1'b1);
endmodule

// File: tb/tb_hsu_top.sv
module tb_hsu_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  BIT = 24;

    // {byte, expected tx counter, expected rx counter}
    localparam logic [23:0] VEC [8] = '{
        {8'h55, 8'd4, 8'd8}, {8'hA3, 8'd3, 8'd7}, {8'h00, 8'd2, 8'd6},
        {8'hFF, 8'd1, 8'd5}, {8'h81, 8'd0, 8'd4}, {8'h3C, 8'd0, 8'd3},
        {8'h7E, 8'd0, 8'd2}, {8'h01, 8'd0, 8'd1}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        txd, rxd, rts, cts = 1'b0;
    logic        loopback = 1'b1, bench_rxd = 1'b1;
    int          nvec = 0, nerr = 0;
    bit          done = 1'b0;

    assign rxd = loopback ? txd : bench_rxd;
    always #(CLK_PERIOD/2) clk = ~clk;

    hsu_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd), .rxd(rxd),
        .rts(rts), .cts(cts)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic pop();
        @(negedge clk); bus_addr = 3'd0; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wait_rx(input string tag);
        logic [15:0] s;
        int k = 0;
        s = '0;
        while (k < 1000) begin
            rd(3'd1, s);
            if (s[2]) break;
            k++;
        end
        chk(tag, {15'd0, s[2]}, 16'd1);
    endtask

    task automatic wait_fall(input int limit, output int k);
        k = 0;
        while (txd !== 1'b0 && k < limit) begin @(negedge clk); k++; end
    endtask

    task automatic send_raw(input logic [7:0] b, input bit good_stop);
        @(negedge clk); bench_rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            bench_rxd = b[i];
            repeat (BIT) @(negedge clk);
        end
        if (good_stop) begin
            bench_rxd = 1'b1; repeat (BIT) @(negedge clk);
        end else begin
            bench_rxd = 1'b0; repeat (18) @(negedge clk); bench_rxd = 1'b1;
        end
        repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++; nvec++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int k;
        v = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd1, v); chk("R1 status", v, 16'h0002);
        rd(3'd2, v); chk("R1 divisor", v, 16'h0017);
        rd(3'd3, v); chk("R1 txcnt", v, 16'h0000);
        rd(3'd4, v); chk("R1 rxcnt", v, 16'h0000);
        chk("R1 txd/rts", {14'd0, txd, rts}, 16'h0002);

        // R2 divisor legality
        wr(3'd2, 16'd22);   rd(3'd2, v); chk("R2 below min", v, 16'd23);
        wr(3'd2, 16'd5000); rd(3'd2, v); chk("R2 above max", v, 16'd23);
        wr(3'd2, 16'hE017); rd(3'd2, v); chk("R2 upper bits", v, 16'd23);
        wr(3'd2, 16'd4999); rd(3'd2, v); chk("R2 max ok", v, 16'd4999);

        // R2 bit period: 0x00 gives start plus 8 zero bits = 9*(29+1) low cycles
        wr(3'd2, 16'd29);
        wr(3'd0, 16'h0000);
        wait_fall(200, k);
        k = 0;
        while (txd === 1'b0 && k < 1000) begin @(negedge clk); k++; end
        chk("R2 low run length", 16'(k), 16'd270);
        wait_rx("R7 rx at div 29");
        rd(3'd0, v); chk("R7 data at div 29", v, 16'h0000);
        pop();
        repeat (40) @(negedge clk);
        wr(3'd2, 16'd23);

        // Vector table: loopback bytes, block counters (R11), cts ignored with gating off (R6)
        wr(3'd3, 16'd5); wr(3'd4, 16'd9);
        rd(3'd3, v); chk("R11 txcnt load", v, 16'd5);
        for (int i = 0; i < 8; i++) begin
            wr(3'd0, {8'd0, VEC[i][23:16]});
            wait_rx("R7 vector arrives");
            rd(3'd0, v); chk("R7 vector data", v, {8'd0, VEC[i][23:16]});
            pop();
            repeat (20) @(negedge clk);
            rd(3'd3, v); chk("R11 txcnt step", v, {8'd0, VEC[i][15:8]});
            rd(3'd4, v); chk("R11 rxcnt step", v, {8'd0, VEC[i][7:0]});
        end
        rd(3'd1, v); chk("R7 fifo empty after pops", {15'd0, v[2]}, 16'd0);

        // R3 frame order and R4 start latency, byte 0x01
        wr(3'd0, 16'h0001);
        rd(3'd1, v); chk("R4 ready low after write", {15'd0, v[1]}, 16'd0);
        wait_fall(100, k);
        chk("R4 start within one bit", {15'd0, k <= BIT}, 16'd1);
        repeat (12) @(negedge clk);
        chk("R3 start bit", {15'd0, txd}, 16'd0);
        for (int j = 0; j < 8; j++) begin
            repeat (BIT) @(negedge clk);
            chk("R3 data bit", {15'd0, txd}, (j == 0) ? 16'd1 : 16'd0);
        end
        repeat (BIT) @(negedge clk);
        chk("R3 stop bit", {15'd0, txd}, 16'd1);
        wait_rx("R7 0x01 arrives");
        pop();
        repeat (40) @(negedge clk);

        // R5 ready at the last data bit, back-to-back bytes
        wr(3'd0, 16'h00C3);
        wait_fall(100, k);
        repeat (189) @(negedge clk);
        rd(3'd1, v); chk("R5 ready before last bit", {15'd0, v[1]}, 16'd0);
        repeat (2) @(negedge clk);
        rd(3'd1, v); chk("R5 ready at last bit", {15'd0, v[1]}, 16'd1);
        wr(3'd0, 16'h005A);
        repeat (600) @(negedge clk);
        rd(3'd0, v); chk("R5 first byte", v, 16'h00C3); pop();
        rd(3'd0, v); chk("R5 queued byte", v, 16'h005A); pop();

        // R4 write while not ready is ignored
        wr(3'd0, 16'h00AA);
        wr(3'd0, 16'h0011);
        repeat (600) @(negedge clk);
        rd(3'd0, v); chk("R4 accepted byte", v, 16'h00AA); pop();
        rd(3'd1, v); chk("R4 ignored write", {15'd0, v[2]}, 16'd0);

        // R6 gated start
        wr(3'd1, 16'h0001);
        cts = 1'b0;
        wr(3'd0, 16'h0096);
        k = 0;
        for (int j = 0; j < 100; j++) begin @(negedge clk); if (txd !== 1'b1) k++; end
        chk("R6 held while cts low", 16'(k), 16'd0);
        chk("R6 rts high", {15'd0, rts}, 16'd1);
        @(negedge clk); cts = 1'b1;
        wait_fall(50, k);
        chk("R6 start after cts", {15'd0, k <= 5}, 16'd1);
        repeat (280) @(negedge clk);
        chk("R6 rts low when idle", {15'd0, rts}, 16'd0);
        rd(3'd0, v); chk("R6 gated byte received", v, 16'h0096); pop();
        wr(3'd1, 16'h0000); cts = 1'b0;

        // R10 framing error
        loopback = 1'b0;
        send_raw(8'h3A, 1'b0);
        rd(3'd1, v); chk("R10 ferr flag, no data", v & 16'h0014, 16'h0010);
        send_raw(8'hC5, 1'b1);
        rd(3'd0, v); chk("R7 external byte", v, 16'h00C5); pop();
        wr(3'd1, 16'h0010);
        rd(3'd1, v); chk("R10 ferr cleared", {15'd0, v[4]}, 16'd0);
        loopback = 1'b1;

        // R8 / R9 fill and overflow
        for (int i = 0; i < 8; i++) begin
            wr(3'd0, 16'(8'h10 + i));
            repeat (260) @(negedge clk);
        end
        rd(3'd1, v); chk("R8 pkt ready, no ovf", v & 16'h0028, 16'h0008);
        wr(3'd0, 16'h00EE);
        repeat (260) @(negedge clk);
        rd(3'd1, v); chk("R9 overflow set", {15'd0, v[5]}, 16'd1);
        for (int i = 0; i < 8; i++) begin
            rd(3'd0, v); chk("R9 order kept", v, 16'(8'h10 + i)); pop();
            if (i == 0) begin
                rd(3'd1, v); chk("R8 pkt ready clears", {15'd0, v[3]}, 16'd0);
            end
        end
        rd(3'd1, v); chk("R9 dropped byte absent", {15'd0, v[2]}, 16'd0);
        wr(3'd1, 16'h0020);
        rd(3'd1, v); chk("R9 overflow cleared", {15'd0, v[5]}, 16'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule